// File: doc/BRIEF.md
# Prioritized Change/Level Interrupt Controller

This block watches eight asynchronous digital inputs and raises one active-low interrupt request when a watched condition occurs. Each channel has three control bits. The mask bit lets the channel interrupt. The mode bit chooses between reacting to any transition and reacting to a level. The level bit chooses which level counts as a match. A channel that sees its condition latches a pending bit. Software clears a pending bit by writing a one to the bit's position. If a level condition is still present when its bit is cleared, the bit sets again at once.

When several channels are pending, the highest-numbered one is served first. An 8-bit vector carries a 5-bit value that software writes, above the 3-bit number of the channel being served. The vector can be read as a register. It is also driven on the acknowledge data bus during an acknowledge cycle that selects request line 0.

Register access is a simple single-cycle write port and a combinational read port. The bus decode that feeds these ports lives outside the block.

Top module: `irqc_top`

## Requirements
- R1: The mask register (address 0) enables channel i when bit i is 1. While bit i is 0, channel i never sets its pending bit. The mask register resets to 0.
- R2: The mode register (address 1) selects transition mode for channel i when bit i is 1. In transition mode, any change of the synchronized input sets the pending bit.
- R3: When mode bit i is 0, channel i sets its pending bit while its input equals level bit i of the level register (address 2). In transition mode the level bit has no effect.
- R4: The pending register (address 3) reads 1 for each pending channel. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R5: If a level-mode match still holds when its pending bit is cleared, the pending bit reads 1 again on the next read.
- R6: `irqN` is 0 while any channel is both pending and enabled. Channel 7 has the highest priority and channel 0 the lowest. After the served channel is cleared, the request stays low for the next pending channel.
- R7: The vector register (address 4) reads with bits 7:3 holding the value last written to bits 7:3, and bits 2:0 holding the highest pending enabled channel (0 when none is pending). The vector resets to 0.
- R8: An acknowledge cycle never clears a pending bit and never releases `irqN`. Only writes to the pending register do.
- R9: While `ackValid` is 1 and `ackLine` is 0, `ackData` carries the vector. For any other `ackLine`, or when `ackValid` is 0, `ackData` is 0.
- R10: An input change made between two rising edges shows up in `irqN` at the third rising edge after the change (two synchronizer stages plus the pending register).
- R11: If a new event and a write-1-to-clear hit the same pending bit in the same cycle, the bit stays set.
- R12: All registers reset to 0, and reads of addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chanIn | input | 8 | Asynchronous monitored inputs |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 8 | Register read data (combinational) |
| ackValid | input | 1 | Interrupt acknowledge cycle active |
| ackLine | input | 2 | Request line being acknowledged |
| ackData | output | 8 | Vector during a line-0 acknowledge, else 0 |
| irqN | output | 1 | Active-low interrupt request |

## Verification
The assertions run on every cycle. They check that a masked channel never gains a pending bit and that a pending bit only falls in the cycle after a pending-register write that carried a one in that position. They also check that an acknowledge alone never drops a pending bit, that the acknowledged vector always names the highest pending enabled channel, and that acknowledges on other lines return zero. Some behaviour only the bench scenarios can show: the exact three-edge latency, the immediate re-set of a persisting level match, a new event winning over a same-cycle clear, and pending patterns across random mixes of mode, level and mask bits.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int REG_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_MASK  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MODE  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_LEVEL = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_PEND  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_VEC   = 3'd4;

  // Strobes from control to datapath
  typedef struct packed {
    logic             maskWr;
    logic             modeWr;
    logic             levelWr;
    logic             pendClr;
    logic             vecWr;
    logic [REG_W-1:0] data;
  } irqc_strobe_t;
endpackage

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int VEC_W       = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_CH-1:0]  chanIn,
  input  irqc_strobe_t       strobe,
  output logic [NUM_CH-1:0]  maskQ,
  output logic [NUM_CH-1:0]  modeQ,
  output logic [NUM_CH-1:0]  levelQ,
  output logic [NUM_CH-1:0]  pendQ,
  output logic [VEC_W-1:0]   vector
);
  localparam int IDX_W  = $clog2(NUM_CH);
  localparam int USER_W = VEC_W - IDX_W;

  logic [NUM_CH-1:0] syncPipe [SYNC_STAGES];
  logic [NUM_CH-1:0] syncOut;
  logic [NUM_CH-1:0] prevQ;
  logic [NUM_CH-1:0] eventVec;
  logic [NUM_CH-1:0] activeVec;
  logic [USER_W-1:0] userQ;
  logic [IDX_W-1:0]  topIdx;

  // Input synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncPipe[s] <= '0;
    end else begin
      syncPipe[0] <= chanIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncPipe[s] <= syncPipe[s-1];
    end
  end
  assign syncOut = syncPipe[SYNC_STAGES-1];

  // Previous sample for transition detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= syncOut;
  end

  // Per-channel event detection
  for (genvar g = 0; g < NUM_CH; g++) begin : gen_detect
    logic hitChange;
    logic hitLevel;
    assign hitChange   = syncOut[g] ^ prevQ[g];
    assign hitLevel    = ~(syncOut[g] ^ levelQ[g]);
    assign eventVec[g] = maskQ[g] & (modeQ[g] ? hitChange : hitLevel);
  end

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ  <= '0;
      modeQ  <= '0;
      levelQ <= '0;
      userQ  <= '0;
    end else begin
      if (strobe.maskWr)  maskQ  <= strobe.data[NUM_CH-1:0];
      if (strobe.modeWr)  modeQ  <= strobe.data[NUM_CH-1:0];
      if (strobe.levelWr) levelQ <= strobe.data[NUM_CH-1:0];
      if (strobe.vecWr)   userQ  <= strobe.data[VEC_W-1:IDX_W];
    end
  end

  // Pending bits: a new event wins over a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
    end else begin
      pendQ <= (pendQ & ~(strobe.pendClr ? strobe.data[NUM_CH-1:0] : '0)) | eventVec;
    end
  end

  // Highest-numbered pending enabled channel
  assign activeVec = pendQ & maskQ;
  always_comb begin
    topIdx = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (activeVec[i]) topIdx = IDX_W'(i);
    end
  end

  assign vector = {userQ, topIdx};
endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int VEC_W  = 8
) (
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [REG_W-1:0]   wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [REG_W-1:0]   rdData,
  input  logic               ackValid,
  input  logic [1:0]         ackLine,
  output logic [VEC_W-1:0]   ackData,
  input  logic [NUM_CH-1:0]  maskQ,
  input  logic [NUM_CH-1:0]  modeQ,
  input  logic [NUM_CH-1:0]  levelQ,
  input  logic [NUM_CH-1:0]  pendQ,
  input  logic [VEC_W-1:0]   vector,
  output irqc_strobe_t       strobe
);
  // Write decode
  always_comb begin
    strobe         = '0;
    strobe.data    = wrData;
    strobe.maskWr  = wrEn && (wrAddr == ADDR_MASK);
    strobe.modeWr  = wrEn && (wrAddr == ADDR_MODE);
    strobe.levelWr = wrEn && (wrAddr == ADDR_LEVEL);
    strobe.pendClr = wrEn && (wrAddr == ADDR_PEND);
    strobe.vecWr   = wrEn && (wrAddr == ADDR_VEC);
  end

  // Read mux
  always_comb begin
    case (rdAddr)
      ADDR_MASK:  rdData = REG_W'(maskQ);
      ADDR_MODE:  rdData = REG_W'(modeQ);
      ADDR_LEVEL: rdData = REG_W'(levelQ);
      ADDR_PEND:  rdData = REG_W'(pendQ);
      ADDR_VEC:   rdData = REG_W'(vector);
      default:    rdData = '0;
    endcase
  end

  // Acknowledge: only request line 0 returns the vector
  assign ackData = (ackValid && ackLine == 2'd0) ? vector : '0;
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] chanIn,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic [2:0] rdAddr,
  output logic [7:0] rdData,
  input  logic       ackValid,
  input  logic [1:0] ackLine,
  output logic [7:0] ackData,
  output logic       irqN
);
  localparam int NUM_CH = 8;
  localparam int VEC_W  = 8;

  irqc_strobe_t      strobe;
  logic [NUM_CH-1:0] maskQ, modeQ, levelQ, pendQ;
  logic [VEC_W-1:0]  vector;

  irqc_ctrl #(.NUM_CH(NUM_CH), .VEC_W(VEC_W)) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .ackValid(ackValid), .ackLine(ackLine), .ackData(ackData),
    .maskQ(maskQ), .modeQ(modeQ), .levelQ(levelQ), .pendQ(pendQ),
    .vector(vector), .strobe(strobe)
  );

  irqc_datapath #(.NUM_CH(NUM_CH), .SYNC_STAGES(2), .VEC_W(VEC_W)) u_dp (
    .clk(clk), .rstN(rstN), .chanIn(chanIn), .strobe(strobe),
    .maskQ(maskQ), .modeQ(modeQ), .levelQ(levelQ), .pendQ(pendQ),
    .vector(vector)
  );

  assign irqN = ~|(pendQ & maskQ);
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [2:0] wrAddr,
  input logic [7:0] wrData,
  input logic       ackValid,
  input logic [1:0] ackLine,
  input logic [7:0] ackData,
  input logic [7:0] pendQ,
  input logic [7:0] maskQ,
  input logic       irqN
);
  logic [7:0] pendMasked;
  assign pendMasked = pendQ & maskQ;

  AST_MASKED_NO_SET: assert property (@(posedge clk) disable iff (!rstN)
    ((pendQ & ~$past(pendQ) & ~$past(maskQ)) == 8'h00)); // R1

  AST_CLEAR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ((($past(pendQ) & ~pendQ) &
      ~(($past(wrEn) && $past(wrAddr) == 3'd3) ? $past(wrData) : 8'h00)) == 8'h00)); // R4

  AST_ACK_NO_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ackValid) && !$past(wrEn)) |-> (($past(pendQ) & ~pendQ) == 8'h00)); // R8

  AST_VECTOR_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (!irqN && ackValid && ackLine == 2'd0) |-> ((pendMasked >> ackData[2:0]) == 8'h01)); // R6

  AST_OTHER_LINE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && ackLine != 2'd0) |-> (ackData == 8'h00)); // R9
endmodule

bind irqc_top irqc_checker u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .ackValid(ackValid), .ackLine(ackLine), .ackData(ackData),
  .pendQ(pendQ), .maskQ(maskQ), .irqN(irqN)
);

// File: tb/irqc_top_tb.sv
`timescale 1ns/1ps
module irqc_top_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] chanIn = '0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       ackValid = 1'b0;
  logic [1:0] ackLine = '0;
  logic [7:0] ackData;
  logic       irqN;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irqc_top u_dut (
    .clk(clk), .rstN(rstN), .chanIn(chanIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .ackValid(ackValid),
    .ackLine(ackLine), .ackData(ackData), .irqN(irqN)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rdAddr = a;
    #1 d = rdData;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Expected pending bits: first input pattern held, clear, then second pattern
  function automatic logic [7:0] expPend(input logic [7:0] en, input logic [7:0] ty,
      input logic [7:0] pol, input logic [7:0] in0, input logic [7:0] in1);
    logic [7:0] lvl0, lvl1;
    lvl0 = ~(in0 ^ pol);
    lvl1 = ~(in1 ^ pol);
    return en & ((ty & (in0 ^ in1)) | (~ty & (lvl0 | lvl1)));
  endfunction

  function automatic logic [2:0] topOf(input logic [7:0] p);
    logic [2:0] t = 3'd0;
    for (int i = 0; i < 8; i++) if (p[i]) t = 3'(i);
    return t;
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5eed_1234));
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(2);

    // R12 reset state
    for (int a = 0; a < 8; a++) begin
      regRead(3'(a), d);
      check("R12 reset read", d, 8'h00);
    end
    check("R6 idle irqN", irqN, 1'b1);
    ackValid = 1'b1; #1;
    check("R9 idle ack", ackData, 8'h00);
    ackValid = 1'b0;

    // R10 latency: level-high on channel 3
    regWrite(3'd2, 8'h08);
    regWrite(3'd0, 8'h08);
    @(negedge clk); chanIn[3] = 1'b1;
    @(posedge clk); #1 check("R10 edge1", irqN, 1'b1);
    @(posedge clk); #1 check("R10 edge2", irqN, 1'b1);
    @(posedge clk); #1 check("R10 edge3", irqN, 1'b0);

    // R5 persistent level re-sets after clear
    regWrite(3'd3, 8'h08);
    regRead(3'd3, d);
    check("R5 level re-set", d, 8'h08);
    // R8 acknowledge holds the request
    ackValid = 1'b1; ackLine = 2'd0;
    waitCycles(4);
    check("R8 irq held", irqN, 1'b0);
    check("R9 line0 vector", ackData, 8'h03);
    ackLine = 2'd2; #1;
    check("R9 other line", ackData, 8'h00);
    ackValid = 1'b0; ackLine = 2'd0;
    chanIn[3] = 1'b0;
    waitCycles(4);
    regWrite(3'd3, 8'h08);
    regRead(3'd3, d);
    check("R4 clear", d, 8'h00);
    check("R6 released", irqN, 1'b1);

    // R1 masked channel never sets
    regWrite(3'd0, 8'h00);
    regWrite(3'd2, 8'h00);
    waitCycles(5);
    regRead(3'd3, d);
    check("R1 masked", d, 8'h00);

    // R3 level bit ignored in transition mode; R11 event beats clear
    regWrite(3'd1, 8'h20);
    regWrite(3'd2, 8'h20);
    regWrite(3'd0, 8'h20);
    waitCycles(5);
    regRead(3'd3, d);
    check("R3 polarity ignored", d, 8'h00);
    @(negedge clk); chanIn[5] = 1'b1;
    waitCycles(5);
    regRead(3'd3, d);
    check("R2 rise sets", d, 8'h20);
    @(negedge clk); chanIn[5] = 1'b0;
    @(posedge clk); @(posedge clk);
    regWrite(3'd3, 8'h20);
    regRead(3'd3, d);
    check("R11 event wins", d, 8'h20);
    regWrite(3'd3, 8'h20);
    regRead(3'd3, d);
    check("R4 write 1 clears", d, 8'h00);

    // Random mixes
    for (int it = 0; it < 40; it++) begin
      logic [7:0] en, ty, pol, in0, in1, pend, bitM;
      logic [4:0] user;
      en = 8'($urandom); ty = 8'($urandom); pol = 8'($urandom);
      in0 = 8'($urandom); in1 = 8'($urandom); user = 5'($urandom);
      if (it == 0) begin ty = 8'h00; pol = 8'hff; in0 = 8'hff; in1 = 8'hff; en = 8'hff; end
      regWrite(3'd0, 8'h00);
      regWrite(3'd1, ty);
      regWrite(3'd2, pol);
      regWrite(3'd4, {user, 3'b101});
      @(negedge clk); chanIn = in0;
      waitCycles(6);
      regWrite(3'd3, 8'hff);
      regWrite(3'd0, en);
      waitCycles(6);
      regWrite(3'd3, 8'h00);
      @(negedge clk); chanIn = in1;
      waitCycles(6);
      pend = expPend(en, ty, pol, in0, in1);
      regRead(3'd3, d);
      check("R2 R3 pending mix", d, pend);
      check("R6 irq level", irqN, (pend == 0));
      regRead(3'd4, d);
      check("R7 vector read", d, {user, topOf(pend)});
      for (int k = 0; k < 2; k++) begin
        ackValid = 1'b1; #1;
        check("R9 ack vector", ackData, {user, topOf(pend)});
        ackValid = 1'b0;
        if (pend != 0) begin
          bitM = 8'h01 << topOf(pend);
          regWrite(3'd3, bitM);
          pend = (pend & ~bitM) | (bitM & en & ~ty & ~(in1 ^ pol));
          regRead(3'd3, d);
          check("R6 next pending", d, pend);
          check("R6 irq after clear", irqN, (pend == 0));
        end
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule